// File: doc/BRIEF.md
# Prefixed Instruction Word Merger

This front-end decode stage takes a stream of 32-bit instruction words and turns each 64-bit prefixed instruction into a single output record. Each input word arrives with a valid flag, its fetch address and a fetch-failed flag. The stage also obeys a stall input and a flush input. A word whose primary opcode is 1 is a prefix. The stage keeps the prefix's 26-bit payload and the low bits of its address, and emits nothing for that word. The next valid word is the suffix. For it the stage emits one merged record. The record carries the prefix payload, the suffix word, the address of the prefix, a flag saying whether the suffix is allowed under that prefix, a no-op class flag, a base-operand select and a sign-extended displacement.

Words that are not part of a prefixed pair pass through unchanged, with the prefix fields cleared. The output is a registered record. It appears one clock after the cycle in which the input word is accepted, and a word is accepted on any non-stalled, non-flushed clock.

Top module: `pfx_merge_stage`

## Requirements
- R1: An accepted valid word with no prefix pending, no fetch failure and primary opcode (bits 31:26) equal to 1 produces no output record (out_valid=0 on the next cycle). It stores bits 25:0 and makes a prefix pending.
- R2: While a prefix is pending, the next accepted valid word produces one record with out_prefixed=1, out_prefix equal to the stored payload and out_word equal to that word. The pending state is then cleared.
- R3: For a merged record, out_addr is the suffix fetch address with bits 5:2 replaced by bits 5:2 of the prefix fetch address.
- R4: The form is payload bits 25:23. Form 000 is the extended load/store form and form 100 is the modified load/store form. Form 110 is legal only when payload bits 22:20 are 000. Every other form value sets out_illegal.
- R5: For form 100 the legal suffix opcodes are 14, 32, 34, 36, 38, 40, 42, 44, 48, 50, 52 and 54. For form 000 they are 41, 57 and 61. A suffix with opcode 1 (a second prefix) is always illegal.
- R6: out_nop equals payload bit 24 on a merged record. It is independent of out_illegal.
- R7: On a merged record, out_disp is {payload[17:0], word[15:0]} sign-extended from 34 bits. On any other record it is word[15:0] sign-extended.
- R8: out_base_sel is 01 (register) when the RA field (word bits 20:16) is nonzero. When RA is zero it is 10 (prefix address) on a merged record whose payload bit 20 is set, and 00 (zero) in every other case.
- R9: A valid word with the fetch-failed flag set clears any pending prefix. It produces a record with out_fetch_fail=1, out_prefixed=0 and out_illegal=0, but only if the previously accepted cycle did not also carry a fetch failure. Consecutive failures produce a single record.
- R10: A valid word with no prefix pending and opcode other than 1 passes through with out_prefixed=0, out_prefix=0, out_illegal=0, out_nop=0 and an unmodified address.
- R11: Reset and flush clear out_valid and the pending prefix. While stall_i is high, the output record and the pending state hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Discards the output record and any pending prefix |
| stall_i | input | 1 | Holds all state and the output record |
| in_valid | input | 1 | Input word is present |
| in_word | input | 32 | Instruction word |
| in_addr | input | ADDR_W | Fetch address of the word |
| in_fetch_fail | input | 1 | Fetch of this word failed |
| out_valid | output | 1 | Output record is present |
| out_fetch_fail | output | 1 | Record reports a fetch failure |
| out_prefixed | output | 1 | Record is a merged prefix/suffix pair |
| out_prefix | output | 26 | Stored prefix payload, zero if not merged |
| out_word | output | 32 | Suffix or plain word |
| out_addr | output | ADDR_W | Instruction address (prefix address when merged) |
| out_illegal | output | 1 | Suffix is not allowed under the prefix |
| out_nop | output | 1 | Merged record is in the no-op class |
| out_base_sel | output | 2 | Base operand: 00 zero, 01 register, 10 prefix address |
| out_disp | output | ADDR_W | Sign-extended displacement |

## Verification
The properties assume a few things about the inputs. The fetch-failed flag only accompanies a valid word. A prefix and its suffix come from the same 64-byte segment, so the saved bits 5:2 rebuild the right address. Flush wins over stall. The stimulus drives every word on the falling edge with in_valid high and fetch-fail used only alongside it. It places each prefix/suffix pair at adjacent addresses inside one segment, including the last slot of a segment. It raises flush only on cycles with no word present.

// File: rtl/pfx_merge_pkg.sv
package pfx_merge_pkg;

    localparam int WORD_W    = 32;
    localparam int PAYLOAD_W = 26;
    localparam int OPC_W     = 6;
    localparam int IMM_LO_W  = 16;
    localparam int IMM_HI_W  = 18;
    localparam int IMM_W     = IMM_LO_W + IMM_HI_W;

    localparam logic [OPC_W-1:0] OPC_PREFIX = 6'd1;

    // Form field, payload bits 25:23
    localparam logic [2:0] FORM_EXT_LS = 3'b000;
    localparam logic [2:0] FORM_MOD_LS = 3'b100;
    localparam logic [2:0] FORM_REG_RR = 3'b110;

    typedef enum logic [1:0] {
        BASE_ZERO = 2'b00,
        BASE_REG  = 2'b01,
        BASE_PC   = 2'b10
    } base_sel_e;

    function automatic logic [OPC_W-1:0] opcode_of(input logic [WORD_W-1:0] w);
        return w[WORD_W-1 -: OPC_W];
    endfunction

    function automatic logic mod_ls_suffix(input logic [OPC_W-1:0] op);
        case (op)
            6'd14, 6'd32, 6'd34, 6'd36, 6'd38, 6'd40,
            6'd42, 6'd44, 6'd48, 6'd50, 6'd52, 6'd54: return 1'b1;
            default:                                  return 1'b0;
        endcase
    endfunction

    function automatic logic ext_ls_suffix(input logic [OPC_W-1:0] op);
        case (op)
            6'd41, 6'd57, 6'd61: return 1'b1;
            default:             return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pfx_hold.sv
module pfx_hold
    import pfx_merge_pkg::*;
#(
    parameter int LO_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush_i,
    input  logic                 stall_i,
    input  logic                 in_valid,
    input  logic                 in_fetch_fail,
    input  logic [WORD_W-1:0]    in_word,
    input  logic [LO_W-1:0]      in_addr_lo,
    output logic                 pend,
    output logic [PAYLOAD_W-1:0] payload,
    output logic [LO_W-1:0]      addr_lo
);

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            pend    <= 1'b0;
            payload <= '0;
            addr_lo <= '0;
        end else if (!stall_i && in_valid) begin
            if (in_fetch_fail || pend) begin
                pend    <= 1'b0;
                payload <= '0;
                addr_lo <= '0;
            end else if (opcode_of(in_word) == OPC_PREFIX) begin
                pend    <= 1'b1;
                payload <= in_word[PAYLOAD_W-1:0];
                addr_lo <= in_addr_lo;
            end
        end
    end

endmodule

// File: rtl/pfx_suffix_check.sv
module pfx_suffix_check
    import pfx_merge_pkg::*;
(
    input  logic [5:0]       form_bits,   // payload bits 25:20
    input  logic [OPC_W-1:0] suffix_opc,
    output logic             illegal,
    output logic             nop_class
);

    logic [2:0] form;
    logic [2:0] sub;
    logic       ok;

    assign form = form_bits[5:3];
    assign sub  = form_bits[2:0];

    always_comb begin
        if (suffix_opc == OPC_PREFIX) begin
            ok = 1'b0;
        end else begin
            case (form)
                FORM_MOD_LS: ok = mod_ls_suffix(suffix_opc);
                FORM_EXT_LS: ok = ext_ls_suffix(suffix_opc);
                FORM_REG_RR: ok = (sub == 3'b000);
                default:     ok = 1'b0;
            endcase
        end
    end

    assign illegal   = !ok;
    assign nop_class = form_bits[4];

endmodule

// File: rtl/pfx_operand.sv
module pfx_operand
    import pfx_merge_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                prefixed,
    input  logic                rel_bit,
    input  logic [IMM_HI_W-1:0] imm_hi,
    input  logic [4:0]          ra_field,
    input  logic [IMM_LO_W-1:0] imm_lo,
    output base_sel_e           base_sel,
    output logic [ADDR_W-1:0]   disp
);

    localparam int EXT_LONG  = ADDR_W - IMM_W;
    localparam int EXT_SHORT = ADDR_W - IMM_LO_W;

    logic [IMM_W-1:0] wide_imm;

    assign wide_imm = {imm_hi, imm_lo};

    always_comb begin
        if (ra_field != 5'd0)
            base_sel = BASE_REG;
        else if (prefixed && rel_bit)
            base_sel = BASE_PC;
        else
            base_sel = BASE_ZERO;
    end

    always_comb begin
        if (prefixed)
            disp = {{EXT_LONG{wide_imm[IMM_W-1]}}, wide_imm};
        else
            disp = {{EXT_SHORT{imm_lo[IMM_LO_W-1]}}, imm_lo};
    end

endmodule

// File: rtl/pfx_merge_stage.sv
module pfx_merge_stage
    import pfx_merge_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int SEG_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush_i,
    input  logic                 stall_i,
    input  logic                 in_valid,
    input  logic [WORD_W-1:0]    in_word,
    input  logic [ADDR_W-1:0]    in_addr,
    input  logic                 in_fetch_fail,
    output logic                 out_valid,
    output logic                 out_fetch_fail,
    output logic                 out_prefixed,
    output logic [PAYLOAD_W-1:0] out_prefix,
    output logic [WORD_W-1:0]    out_word,
    output logic [ADDR_W-1:0]    out_addr,
    output logic                 out_illegal,
    output logic                 out_nop,
    output logic [1:0]           out_base_sel,
    output logic [ADDR_W-1:0]    out_disp
);

    localparam int LO_W = SEG_BITS - 2;

    typedef struct packed {
        logic                 valid;
        logic                 ff;
        logic                 prefixed;
        logic [PAYLOAD_W-1:0] payload;
        logic [WORD_W-1:0]    word;
        logic [ADDR_W-1:0]    addr;
        logic                 illegal;
        logic                 nop;
        base_sel_e            base_sel;
        logic [ADDR_W-1:0]    disp;
    } rec_t;

    logic                 pend;
    logic [PAYLOAD_W-1:0] payload;
    logic [LO_W-1:0]      addr_lo;
    logic                 ff_seen;
    logic                 merging;
    logic                 chk_illegal;
    logic                 chk_nop;
    base_sel_e            op_base;
    logic [ADDR_W-1:0]    op_disp;
    rec_t                 nxt;
    rec_t                 rec_q;

    pfx_hold #(.LO_W(LO_W)) u_hold (
        .clk           (clk),
        .rst           (rst),
        .flush_i       (flush_i),
        .stall_i       (stall_i),
        .in_valid      (in_valid),
        .in_fetch_fail (in_fetch_fail),
        .in_word       (in_word),
        .in_addr_lo    (in_addr[SEG_BITS-1:2]),
        .pend          (pend),
        .payload       (payload),
        .addr_lo       (addr_lo)
    );

    pfx_suffix_check u_check (
        .form_bits  (payload[25:20]),
        .suffix_opc (opcode_of(in_word)),
        .illegal    (chk_illegal),
        .nop_class  (chk_nop)
    );

    assign merging = pend && !in_fetch_fail;

    pfx_operand #(.ADDR_W(ADDR_W)) u_operand (
        .prefixed (merging),
        .rel_bit  (payload[20]),
        .imm_hi   (payload[IMM_HI_W-1:0]),
        .ra_field (in_word[20:16]),
        .imm_lo   (in_word[IMM_LO_W-1:0]),
        .base_sel (op_base),
        .disp     (op_disp)
    );

    always_comb begin
        nxt          = '0;
        nxt.word     = in_word;
        nxt.addr     = in_addr;
        nxt.base_sel = op_base;
        nxt.disp     = op_disp;
        if (in_fetch_fail) begin
            nxt.valid = in_valid && !ff_seen;
            nxt.ff    = 1'b1;
        end else if (pend) begin
            nxt.valid                 = in_valid;
            nxt.prefixed              = 1'b1;
            nxt.payload               = payload;
            nxt.addr[SEG_BITS-1:2]    = addr_lo;
            nxt.illegal               = chk_illegal;
            nxt.nop                   = chk_nop;
        end else if (opcode_of(in_word) == OPC_PREFIX) begin
            nxt.valid = 1'b0;
        end else begin
            nxt.valid = in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q   <= '0;
            ff_seen <= 1'b0;
        end else if (flush_i) begin
            rec_q.valid <= 1'b0;
            ff_seen     <= 1'b0;
        end else if (!stall_i) begin
            rec_q   <= nxt;
            ff_seen <= in_valid && in_fetch_fail;
        end
    end

    assign out_valid      = rec_q.valid;
    assign out_fetch_fail = rec_q.ff;
    assign out_prefixed   = rec_q.prefixed;
    assign out_prefix     = rec_q.payload;
    assign out_word       = rec_q.word;
    assign out_addr       = rec_q.addr;
    assign out_illegal    = rec_q.illegal;
    assign out_nop        = rec_q.nop;
    assign out_base_sel   = rec_q.base_sel;
    assign out_disp       = rec_q.disp;

endmodule

// File: rtl/pfx_merge_chk.sv
module pfx_merge_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              flush_i,
    input logic              stall_i,
    input logic              in_valid,
    input logic [31:0]       in_word,
    input logic              in_fetch_fail,
    input logic              pend,
    input logic              out_valid,
    input logic              out_fetch_fail,
    input logic              out_prefixed,
    input logic [25:0]       out_prefix,
    input logic [31:0]       out_word,
    input logic              out_illegal,
    input logic              out_nop,
    input logic [1:0]        out_base_sel,
    input logic [ADDR_W-1:0] out_disp
);

    logic acc_ff_q;
    logic adv;

    assign adv = !flush_i && !stall_i;

    always_ff @(posedge clk) begin
        if (rst || flush_i)
            acc_ff_q <= 1'b0;
        else if (!stall_i)
            acc_ff_q <= in_valid && in_fetch_fail;
    end

    p_prefix_silent_r1: assert property (@(posedge clk) disable iff (rst)
        (adv && in_valid && !in_fetch_fail && !pend && in_word[31:26] == 6'd1)
        |=> (!out_valid && pend));

    p_suffix_merge_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && in_valid && !in_fetch_fail && pend)
        |=> (out_valid && out_prefixed && !pend));

    p_form_illegal_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_prefixed && out_prefix[25:23] != 3'b000 &&
         out_prefix[25:23] != 3'b100 && out_prefix[25:23] != 3'b110)
        |-> out_illegal);

    p_disp_sign_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_prefixed)
        |-> (out_disp[ADDR_W-1:33] == {(ADDR_W-33){out_prefix[17]}}));

    p_pc_base_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_prefixed && out_word[20:16] == 5'd0 && out_prefix[20])
        |-> (out_base_sel == 2'b10));

    p_single_fail_r9: assert property (@(posedge clk) disable iff (rst)
        (adv && in_valid && in_fetch_fail && acc_ff_q) |=> !out_valid);

    p_plain_clean_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_prefixed && !out_fetch_fail) |-> (!out_illegal && !out_nop));

    p_flush_clear_r11: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (!out_valid && !pend));

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!flush_i && stall_i)
        |=> ($stable(out_valid) && $stable(pend) && $stable(out_word)));

endmodule

bind pfx_merge_stage pfx_merge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .flush_i        (flush_i),
    .stall_i        (stall_i),
    .in_valid       (in_valid),
    .in_word        (in_word),
    .in_fetch_fail  (in_fetch_fail),
    .pend           (pend),
    .out_valid      (out_valid),
    .out_fetch_fail (out_fetch_fail),
    .out_prefixed   (out_prefixed),
    .out_prefix     (out_prefix),
    .out_word       (out_word),
    .out_illegal    (out_illegal),
    .out_nop        (out_nop),
    .out_base_sel   (out_base_sel),
    .out_disp       (out_disp)
);

// File: tb/pfx_merge_stage_tb.sv
module pfx_merge_stage_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush_i = 1'b0;
    logic        stall_i = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [63:0] in_addr = '0;
    logic        in_fetch_fail = 1'b0;
    logic        out_valid, out_fetch_fail, out_prefixed, out_illegal, out_nop;
    logic [25:0] out_prefix;
    logic [31:0] out_word;
    logic [63:0] out_addr, out_disp;
    logic [1:0]  out_base_sel;

    always #4 clk = ~clk;

    pfx_merge_stage u_dut (
        .clk(clk), .rst(rst), .flush_i(flush_i), .stall_i(stall_i),
        .in_valid(in_valid), .in_word(in_word), .in_addr(in_addr),
        .in_fetch_fail(in_fetch_fail),
        .out_valid(out_valid), .out_fetch_fail(out_fetch_fail),
        .out_prefixed(out_prefixed), .out_prefix(out_prefix),
        .out_word(out_word), .out_addr(out_addr), .out_illegal(out_illegal),
        .out_nop(out_nop), .out_base_sel(out_base_sel), .out_disp(out_disp)
    );

    typedef struct {
        logic        ff;
        logic        prefixed;
        logic [25:0] pl;
        logic [31:0] w;
        logic [63:0] a;
        logic        ill;
        logic        nop;
        logic [1:0]  bs;
        logic [63:0] d;
    } exp_t;

    exp_t  q[$];
    string tq[$];
    int    nchk = 0;
    int    nerr = 0;
    bit    done = 1'b0;

    // bench model state
    bit          m_pend = 1'b0;
    logic [25:0] m_pl = '0;
    logic [3:0]  m_lo = '0;
    bit          m_ffs = 1'b0;

    function automatic logic [31:0] mk(input int op, input int ra, input logic [15:0] imm);
        return {op[5:0], 5'd3, ra[4:0], imm};
    endfunction

    function automatic logic [31:0] mkp(input logic [2:0] form, input logic [2:0] sub,
                                        input logic [17:0] imm);
        return {6'd1, form, sub, 2'b00, imm};
    endfunction

    function automatic bit legal_suffix(input logic [25:0] pl, input logic [5:0] op);
        if (op == 6'd1) return 1'b0;
        if (pl[25:23] == 3'b100)
            return op == 14 || op == 32 || op == 34 || op == 36 || op == 38 || op == 40 ||
                   op == 42 || op == 44 || op == 48 || op == 50 || op == 52 || op == 54;
        if (pl[25:23] == 3'b000)
            return op == 41 || op == 57 || op == 61;
        if (pl[25:23] == 3'b110)
            return pl[22:20] == 3'b000;
        return 1'b0;
    endfunction

    function automatic exp_t plain_exp(input logic [31:0] w, input logic [63:0] a);
        exp_t e;
        e.ff = 0; e.prefixed = 0; e.pl = '0; e.w = w; e.a = a; e.ill = 0; e.nop = 0;
        e.bs = (w[20:16] != 0) ? 2'b01 : 2'b00;
        e.d  = {{48{w[15]}}, w[15:0]};
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input string detail);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: %s", tag, detail);
        end
    endtask

    task automatic send(input logic [31:0] w, input logic [63:0] a, input bit ff,
                        input int nstall, input string tag);
        exp_t e;
        bit   emit;
        @(negedge clk);
        flush_i = 0; in_valid = 1; in_word = w; in_addr = a; in_fetch_fail = ff;
        if (nstall > 0) begin
            logic        sv_valid;
            logic [31:0] sv_word;
            sv_valid = out_valid; sv_word = out_word;
            stall_i = 1;
            repeat (nstall) @(negedge clk);
            check(out_valid == sv_valid && out_word == sv_word, "R11 stall hold",
                  $sformatf("got v=%0b w=%h exp v=%0b w=%h", out_valid, out_word, sv_valid, sv_word));
            stall_i = 0;
        end
        e = plain_exp(w, a);
        emit = 1'b1;
        if (ff) begin
            e.ff = 1; emit = !m_ffs; m_pend = 0;
        end else if (m_pend) begin
            e.prefixed = 1; e.pl = m_pl; e.a[5:2] = m_lo;
            e.ill = !legal_suffix(m_pl, w[31:26]);
            e.nop = m_pl[24];
            e.bs  = (w[20:16] != 0) ? 2'b01 : (m_pl[20] ? 2'b10 : 2'b00);
            e.d   = {{30{m_pl[17]}}, m_pl[17:0], w[15:0]};
            m_pend = 0;
        end else if (w[31:26] == 6'd1) begin
            emit = 0; m_pend = 1; m_pl = w[25:0]; m_lo = a[5:2];
        end
        m_ffs = ff;
        if (emit) begin q.push_back(e); tq.push_back(tag); end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        flush_i = 0; in_valid = 0; in_fetch_fail = 0;
        m_ffs = 0;
        @(posedge clk);
    endtask

    task automatic do_flush();
        @(negedge clk);
        in_valid = 0; in_fetch_fail = 0; flush_i = 1;
        m_pend = 0; m_ffs = 0;
        @(posedge clk);
        @(negedge clk);
        flush_i = 0;
        check(out_valid == 0, "R11 flush clears output",
              $sformatf("got out_valid=%0b exp 0", out_valid));
    endtask

    // monitor
    bit adv_q = 0;
    always @(posedge clk) adv_q <= !rst && !flush_i && !stall_i;

    always @(negedge clk) begin
        if (adv_q && out_valid && !done) begin
            if (q.size() == 0) begin
                check(0, "unexpected record", $sformatf("got word=%h exp none", out_word));
            end else begin
                exp_t  e;
                string t;
                e = q.pop_front();
                t = tq.pop_front();
                check(out_fetch_fail == e.ff && out_prefixed == e.prefixed &&
                      out_prefix == e.pl && out_word == e.w && out_addr == e.a &&
                      out_illegal == e.ill && out_nop == e.nop &&
                      out_base_sel == e.bs && out_disp == e.d, t,
                      $sformatf("got ff=%0b px=%0b pl=%h w=%h a=%h ill=%0b nop=%0b bs=%0d d=%h exp ff=%0b px=%0b pl=%h w=%h a=%h ill=%0b nop=%0b bs=%0d d=%h",
                                out_fetch_fail, out_prefixed, out_prefix, out_word, out_addr,
                                out_illegal, out_nop, out_base_sel, out_disp,
                                e.ff, e.prefixed, e.pl, e.w, e.a, e.ill, e.nop, e.bs, e.d));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            nerr++; nchk++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    localparam logic [63:0] SEG = 64'h0000_0040_0000_1000;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check(out_valid == 0, "R11 reset state", $sformatf("got out_valid=%0b exp 0", out_valid));

        // plain pass-through, negative displacement
        send(mk(14, 4, 16'hFFF0), SEG + 64'h00, 0, 0, "R10 plain addi R7");
        send(mk(32, 0, 16'h0010), SEG + 64'h04, 0, 0, "R10 plain lwz R8 zero base");
        // modified form, RA nonzero, register base
        send(mkp(3'b100, 3'b000, 18'h00001), SEG + 64'h08, 0, 0, "R1 prefix");
        send(mk(14, 5, 16'h1234), SEG + 64'h0C, 0, 0, "R2 R5 R7 merged addi");
        // pc-relative at last slot of a segment, suffix crosses nothing
        send(mkp(3'b100, 3'b001, 18'h3FFFF), SEG + 64'h38, 0, 0, "R1 prefix");
        send(mk(32, 0, 16'h8000), SEG + 64'h3C, 0, 0, "R3 R8 R7 pc-relative lwz");
        // modified form, disallowed suffix opcode
        send(mkp(3'b100, 3'b000, 18'h1FFFF), SEG + 64'h10, 0, 0, "R1 prefix");
        send(mk(41, 2, 16'hFFFF), SEG + 64'h14, 0, 0, "R5 op41 under modified form R7");
        // extended form
        send(mkp(3'b000, 3'b000, 18'h20000), SEG + 64'h18, 0, 0, "R1 prefix");
        send(mk(57, 0, 16'h0000), SEG + 64'h1C, 0, 0, "R5 op57 extended form R7");
        send(mkp(3'b000, 3'b001, 18'h0), SEG + 64'h20, 0, 0, "R1 prefix");
        send(mk(14, 0, 16'h0004), SEG + 64'h24, 0, 0, "R5 op14 under extended form");
        // reg-reg form: legal no-op and illegal subtype
        send(mkp(3'b110, 3'b000, 18'h0), SEG + 64'h28, 0, 0, "R1 prefix");
        send(mk(24, 0, 16'h0), SEG + 64'h2C, 0, 0, "R4 R6 no-op legal");
        send(mkp(3'b110, 3'b010, 18'h0), SEG + 64'h30, 0, 0, "R1 prefix");
        send(mk(24, 0, 16'h0), SEG + 64'h34, 0, 0, "R4 R6 no-op bad subtype");
        // other forms
        send(mkp(3'b010, 3'b000, 18'h5), SEG + 64'h40, 0, 0, "R1 prefix");
        send(mk(14, 1, 16'h0), SEG + 64'h44, 0, 0, "R4 R6 form 010 illegal nop class");
        send(mkp(3'b101, 3'b000, 18'h5), SEG + 64'h48, 0, 0, "R1 prefix");
        send(mk(32, 1, 16'h0), SEG + 64'h4C, 0, 0, "R4 form 101 illegal");
        // second prefix as suffix
        send(mkp(3'b100, 3'b000, 18'h7), SEG + 64'h50, 0, 0, "R1 prefix");
        send(mkp(3'b100, 3'b000, 18'h9), SEG + 64'h54, 0, 0, "R5 second prefix illegal");
        send(mk(14, 0, 16'h0001), SEG + 64'h58, 0, 0, "R10 after double prefix");
        // stall on a suffix
        send(mkp(3'b100, 3'b001, 18'h00123), SEG + 64'h60, 0, 2, "R1 prefix stalled");
        send(mk(34, 0, 16'h0042), SEG + 64'h64, 0, 3, "R11 R2 stalled suffix");
        // flush drops a pending prefix
        send(mkp(3'b100, 3'b000, 18'h1), SEG + 64'h68, 0, 0, "R1 prefix");
        do_flush();
        send(mk(14, 6, 16'h0002), SEG + 64'h6C, 0, 0, "R11 R10 word after flush");
        // fetch failure while pending, consecutive failures
        send(mkp(3'b100, 3'b000, 18'h1), SEG + 64'h70, 0, 0, "R1 prefix");
        send(mk(32, 2, 16'h0), SEG + 64'h74, 1, 0, "R9 fetch fail clears prefix");
        send(mk(32, 2, 16'h0), SEG + 64'h78, 1, 0, "R9 repeated fail");
        send(mk(38, 7, 16'h0100), SEG + 64'h7C, 0, 0, "R9 R10 word after fail");
        idle();
        send(mk(32, 2, 16'h0), SEG + 64'h80, 1, 0, "R9 new fail after gap");
        idle();
        idle();
        idle();

        check(q.size() == 0, "R2 all expected records seen",
              $sformatf("got pending=%0d exp 0", q.size()));
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule